// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus agent. When the agent owns the bus data lines for a phase, the block computes the parity bit over the data word and the four command/byte-enable lines. It drives that bit onto the parity line one clock later. It drives only for an address it issues as initiator, for write data it issues as initiator, and for read data it returns as target.

When the agent receives an address or a completed data phase, the block keeps the parity of what it saw and compares it with the parity bit that arrives on the next clock. A mismatch on ordinary data pulls the data-error line low two clocks after the data phase. Each erroneous phase adds at least one low clock, and the line is driven high for one clock before it is released. A mismatch on a received address, or on data that belongs to a broadcast (special) command, produces a single-clock low pulse on the open-drain system-error line instead.

A sticky flag records every detected error. Two enable inputs gate the reporting on the two error lines. The bus reset is asynchronous: it releases every output at once and clears all state.

Top module: `bus_parity_unit`

## Requirements
- R1: When the parity output is enabled, its value makes the count of ones over the 32 data bits, the 4 command/byte-enable bits and the parity bit even, where the data and command bits are those on the bus one clock earlier.
- R2: The parity output enable is high exactly one clock after a cycle in which the agent owns the data lines. Those cycles are an address phase as initiator, a data-phase cycle (frame or initiator-ready low, not an address phase) as initiator writing, and a data-phase cycle as target reading. In every other case the enable is low.
- R3: A parity check is made only for an address phase received as target, and for a completed data phase (initiator-ready and target-ready both low) received as initiator reading or as target writing. Wait cycles, phases the agent drives itself and idle cycles never report an error.
- R4: A data parity error on a non-broadcast command drives the data-error line low in the second clock after the data phase, which is the clock after the parity bit for that phase arrived.
- R5: Data-error low time is one clock per erroneous phase. Errors on back-to-back completed phases give one continuous low stretch.
- R6: After its last low clock, the data-error line is driven high with its enable on for exactly one clock, and then its enable goes low.
- R7: The command code 4'b0001 on the command lines during an address phase marks a broadcast transaction. A data parity error inside one goes to the system-error line and not the data-error line. A parity error on a received address also goes to the system-error line, two clocks after the address phase.
- R8: The system-error line is driven low for one clock per reported error. Its enable is never on while its value is high.
- R9: Pulling the reset low turns off all three output enables and clears the sticky flag at once, with no clock edge needed, and no error pending before reset is reported afterwards.
- R10: With its enable input low, the data-error line stays released. With its own enable low, the system-error line stays released. Errors are still detected.
- R11: The sticky error flag goes high in the clock after any detected address or data parity error, whatever the enables are. It is cleared by a high clear input, and a new error in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous bus reset, active low |
| adIn | input | 32 | Address/data lines as seen on the bus |
| cbeN | input | 4 | Command/byte-enable lines as seen on the bus |
| parIn | input | 1 | Parity line as seen on the bus |
| frameN | input | 1 | Frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| isMaster | input | 1 | Agent is the initiator of the current transaction |
| isRead | input | 1 | Current transaction is a read |
| addrPhase | input | 1 | Current clock is an address phase |
| perrEn | input | 1 | Enables reporting on the data-error line |
| serrEn | input | 1 | Enables reporting on the system-error line |
| errFlagClr | input | 1 | Clears the sticky error flag |
| parOut | output | 1 | Parity value to drive |
| parOe | output | 1 | Parity output enable |
| perrNOut | output | 1 | Data-error value, active low |
| perrOe | output | 1 | Data-error output enable |
| serrNOut | output | 1 | System-error value, active low, open drain |
| serrOe | output | 1 | System-error output enable |
| errFlag | output | 1 | Sticky parity-error flag |

## Verification
A wrong stored parity value shows on the parity output in the very next clock. It also shows as a false or missing error two clocks after a received phase. A check strobe that is lost or taken on a wait cycle makes the data-error line fall or stay high in the second clock after the phase. A stale broadcast latch sends the error to the wrong line in that same clock. A broken park register shows one clock later, as a missing high clock or an enable that stays on. The bench runs walking-bit data through every ownership role, with errors on single, wait-separated and consecutive phases, and compares every output after every clock edge.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
  localparam int CMD_W = 4;
  // command code on the C/BE lines that marks a broadcast transaction
  localparam logic [CMD_W-1:0] CMD_BROADCAST = 4'b0001;

  // strobes from control to datapath, valid in the cycle the bus carries the word
  typedef struct packed {
    logic capture;   // keep the parity of the current word
    logic drivePar;  // drive that parity during the next clock
  } dpStrobe_t;
endpackage

// File: rtl/bus_parity_dp.sv
module bus_parity_dp
  import bus_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  logic [LANES-1:0]  cbeN,
  input  logic              parIn,
  input  dpStrobe_t         strobe,
  output logic              parOut,
  output logic              parOe,
  output logic              parMismatch
);
  logic [LANES-1:0] lanePar;
  logic             wordPar;
  logic             parReg;
  logic             parOeQ;

  // one partial parity per byte lane, each including its own C/BE bit
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lanePar[g] = (^adIn[g*LANE_W +: LANE_W]) ^ cbeN[g];
  end
  assign wordPar = ^lanePar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parReg <= 1'b0;
      parOeQ <= 1'b0;
    end else begin
      if (strobe.capture) parReg <= wordPar;
      parOeQ <= strobe.drivePar;
    end
  end

  assign parOut      = parReg;
  assign parOe       = parOeQ;
  assign parMismatch = parIn ^ parReg;

  // R1: the driven bit makes the previous clock's word plus itself even
  assert_par_even_R1: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ((parOut ^ $past(^{adIn, cbeN})) == 1'b0));
endmodule

// File: rtl/bus_parity_ctrl.sv
module bus_parity_ctrl
  import bus_parity_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] cbeN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic             trdyN,
  input  logic             isMaster,
  input  logic             isRead,
  input  logic             addrPhase,
  input  logic             perrEn,
  input  logic             serrEn,
  input  logic             errFlagClr,
  input  logic             parMismatch,
  output dpStrobe_t        strobe,
  output logic             perrNOut,
  output logic             perrOe,
  output logic             serrNOut,
  output logic             serrOe,
  output logic             errFlag
);
  logic dataCycle, driveNow, recvAddr, recvData;
  logic errAddr, errData;
  logic chkAddrQ, chkDataQ, bcastQ;
  logic perrLowQ, perrParkQ, serrQ, flagQ;

  always_comb begin
    dataCycle = !addrPhase && (!frameN || !irdyN);
    // the agent owns AD as initiator writing or as target reading
    driveNow  = (addrPhase && isMaster) || (dataCycle && (isMaster != isRead));
    recvAddr  = addrPhase && !isMaster;
    recvData  = !addrPhase && !irdyN && !trdyN && (isMaster == isRead);
    strobe.drivePar = driveNow;
    strobe.capture  = driveNow || recvAddr || recvData;
    errAddr = chkAddrQ && parMismatch;
    errData = chkDataQ && parMismatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkAddrQ  <= 1'b0;
      chkDataQ  <= 1'b0;
      bcastQ    <= 1'b0;
      perrLowQ  <= 1'b0;
      perrParkQ <= 1'b0;
      serrQ     <= 1'b0;
      flagQ     <= 1'b0;
    end else begin
      chkAddrQ  <= recvAddr;
      chkDataQ  <= recvData;
      if (addrPhase) bcastQ <= (cbeN == LANES'(CMD_BROADCAST));
      perrLowQ  <= perrEn && errData && !bcastQ;
      perrParkQ <= perrLowQ;
      serrQ     <= serrEn && (errAddr || (errData && bcastQ));
      if (errAddr || errData) flagQ <= 1'b1;
      else if (errFlagClr)    flagQ <= 1'b0;
    end
  end

  assign perrNOut = !perrLowQ;
  assign perrOe   = perrLowQ || perrParkQ;
  assign serrNOut = !serrQ;
  assign serrOe   = serrQ;
  assign errFlag  = flagQ;

  // R4: a low data-error clock follows a completed data phase by two clocks
  assert_perr_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrNOut) |-> $past(!irdyN && !trdyN, 2));

  // R6: a low clock is always followed by a driven clock
  assert_perr_park_R6: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrNOut) |=> perrOe);

  // R10: data-error reporting only when enabled on the detecting clock
  assert_perr_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (perrOe && !perrNOut) |-> $past(perrEn));

  // R7: a system-error pulse needs a datapath mismatch and the enable
  assert_serr_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> ($past(parMismatch) && $past(serrEn)));
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  logic [LANES-1:0]  cbeN,
  input  logic              parIn,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic              isMaster,
  input  logic              isRead,
  input  logic              addrPhase,
  input  logic              perrEn,
  input  logic              serrEn,
  input  logic              errFlagClr,
  output logic              parOut,
  output logic              parOe,
  output logic              perrNOut,
  output logic              perrOe,
  output logic              serrNOut,
  output logic              serrOe,
  output logic              errFlag
);
  dpStrobe_t strobe;
  logic      parMismatch;

  bus_parity_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uDp (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN), .parIn(parIn),
    .strobe(strobe), .parOut(parOut), .parOe(parOe),
    .parMismatch(parMismatch)
  );

  bus_parity_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .cbeN(cbeN), .frameN(frameN), .irdyN(irdyN),
    .trdyN(trdyN), .isMaster(isMaster), .isRead(isRead),
    .addrPhase(addrPhase), .perrEn(perrEn), .serrEn(serrEn),
    .errFlagClr(errFlagClr), .parMismatch(parMismatch), .strobe(strobe),
    .perrNOut(perrNOut), .perrOe(perrOe), .serrNOut(serrNOut),
    .serrOe(serrOe), .errFlag(errFlag)
  );
endmodule

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b1;
  logic [31:0] adIn = '0;
  logic [3:0] cbeN = '0;
  logic parIn = 1'b0, frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1;
  logic isMaster = 1'b0, isRead = 1'b0, addrPhase = 1'b0;
  logic perrEn = 1'b1, serrEn = 1'b1, errFlagClr = 1'b0;
  logic parOut, parOe, perrNOut, perrOe, serrNOut, serrOe, errFlag;

  bus_parity_unit u0 (
    .clk(clk), .rstN(rstN), .adIn(adIn), .cbeN(cbeN), .parIn(parIn),
    .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN), .isMaster(isMaster),
    .isRead(isRead), .addrPhase(addrPhase), .perrEn(perrEn),
    .serrEn(serrEn), .errFlagClr(errFlagClr), .parOut(parOut),
    .parOe(parOe), .perrNOut(perrNOut), .perrOe(perrOe),
    .serrNOut(serrNOut), .serrOe(serrOe), .errFlag(errFlag)
  );

  int checks = 0, fails = 0;
  string scen = "R3";
  bit done = 0;

  // bench-side expectation state, derived from the requirements
  logic [31:0] hAd = '0;
  logic [3:0]  hCbe = '0;
  logic hRecvAddr = 0, hRecvData = 0, expBcast = 0;
  logic expPerrLow = 0, expFlag = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t: actual %b expected %b", req, scen, $time, act, exp);
    end
  endtask

  task automatic step(input logic addr, input logic mst, input logic rd,
                      input logic fN, input logic iN, input logic tN,
                      input logic [31:0] ad, input logic [3:0] cbe,
                      input logic inj);
    logic drv, errA, errD, newPerr, newSerr;
    @(negedge clk);
    addrPhase = addr; isMaster = mst; isRead = rd;
    frameN = fN; irdyN = iN; trdyN = tN; adIn = ad; cbeN = cbe;
    parIn = (^{hAd, hCbe}) ^ inj;
    drv = (addr && mst) || (!addr && (!fN || !iN) && (mst != rd));
    errA = hRecvAddr && inj;
    errD = hRecvData && inj;
    newPerr = errD && !expBcast && perrEn;
    newSerr = (errA || (errD && expBcast)) && serrEn;
    if (errA || errD) expFlag = 1'b1;
    else if (errFlagClr) expFlag = 1'b0;
    @(posedge clk);
    #1;
    chk("R2", parOe, drv);
    if (drv) chk("R1", parOut, ^{ad, cbe});
    chk("R6", perrOe, newPerr || expPerrLow);
    if (newPerr || expPerrLow) chk("R4", perrNOut, !newPerr);
    chk("R7", serrOe, newSerr);
    if (newSerr) chk("R8", serrNOut, 1'b0);
    chk("R11", errFlag, expFlag);
    expPerrLow = newPerr;
    hAd = ad; hCbe = cbe;
    hRecvAddr = addr && !mst;
    hRecvData = !addr && !iN && !tN && (mst == rd);
    if (addr) expBcast = (cbe == 4'b0001);
  endtask

  task automatic idle(input logic inj);
    step(0, 0, 0, 1, 1, 1, 32'h0, 4'hF, inj);
  endtask

  task automatic resetNow();
    #2 rstN = 1'b0;
    #1;
    chk("R9", parOe, 1'b0);
    chk("R9", perrOe, 1'b0);
    chk("R9", serrOe, 1'b0);
    chk("R9", errFlag, 1'b0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    addrPhase = 0; frameN = 1; irdyN = 1; trdyN = 1; adIn = '0; cbeN = '0;
    rstN = 1'b1;
    hAd = '0; hCbe = '0; hRecvAddr = 0; hRecvData = 0;
    expBcast = 0; expPerrLow = 0; expFlag = 0;
  endtask

  function automatic logic [31:0] walk(input int i);
    return (i < 32) ? (32'h1 << i) : ~(32'h1 << (i - 32));
  endfunction

  initial begin
    scen = "R9";
    resetNow();

    // target write: checks on completed phases, waits ignored, bursts of errors
    for (int pass = 0; pass < 2; pass++) begin
      scen = "R3";
      step(1, 0, 0, 0, 1, 1, 32'h4000_0000 + pass, 4'b0111, 0);
      for (int i = 0; i < 40; i++) begin
        logic w;
        w = (i % 4 == 3) && !(i >= 18 && i <= 25);
        scen = (i >= 18 && i <= 25) ? "R5" : "R3";
        step(0, 0, 0, (i == 39), 0, w, walk(i) ^ pass, 4'(i), (i % 3 == 0) || (i >= 19 && i <= 23));
      end
      idle(1);
      idle(0); idle(0);
    end

    // target read: block drives parity, received parity never checked
    scen = "R3";
    step(1, 0, 1, 0, 1, 1, 32'h0000_1230, 4'b0110, 0);
    for (int i = 0; i < 36; i++)
      step(0, 0, 1, (i == 35), 0, (i % 5 == 2), walk(i), 4'(~i), 1);
    idle(1); idle(0);

    // initiator write: address and data driven, injected errors ignored
    step(1, 1, 0, 0, 1, 1, 32'hDEAD_0000, 4'b0111, 1);
    for (int i = 0; i < 36; i++)
      step(0, 1, 0, (i == 35), (i % 6 == 4), 0, walk(35 - i), 4'(i * 3), 1);
    idle(1); idle(0);

    // initiator read: address driven, data checked
    step(1, 1, 1, 0, 1, 1, 32'h0BAD_F00D, 4'b0110, 0);
    for (int i = 0; i < 36; i++) begin
      scen = (i >= 10 && i <= 14) ? "R5" : "R4";
      step(0, 1, 1, (i == 35), 0, (i % 7 == 6), walk(i), 4'(i), (i % 4 == 1) || (i >= 11 && i <= 14));
    end
    idle(1); idle(0); idle(0);

    // address parity errors as target, over every command code
    scen = "R7";
    for (int c = 0; c < 16; c++) begin
      step(1, 0, c[0], 0, 1, 1, walk(c * 2), 4'(c), 0);
      step(0, 0, c[0], 1, 0, 1, walk(c), 4'hF, (c % 2 == 0));
      idle(0); idle(0);
    end

    // broadcast command: data errors go to the system-error line
    step(1, 0, 0, 0, 1, 1, 32'h0000_0000, 4'b0001, 0);
    for (int i = 0; i < 8; i++)
      step(0, 0, 0, (i == 7), 0, (i == 3), walk(i * 4), 4'b0000, (i == 1) || (i == 5) || (i == 6));
    idle(1); idle(0); idle(0);

    // enables off: nothing reported, flag still set
    scen = "R10";
    perrEn = 0; serrEn = 0;
    errFlagClr = 1; idle(0); errFlagClr = 0;
    step(1, 0, 0, 0, 1, 1, 32'h1111_0000, 4'b0111, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, (i == 5), 0, 0, walk(i + 7), 4'h0, (i > 0));
    idle(1);
    step(1, 0, 0, 0, 1, 1, 32'h2222_0000, 4'b0011, 0);
    step(0, 0, 0, 1, 0, 0, 32'h5, 4'h0, 1);
    idle(0); idle(0);
    perrEn = 1; serrEn = 1;

    // sticky flag: clear, then error in the same clock as clear wins
    scen = "R11";
    errFlagClr = 1; idle(0); idle(0); errFlagClr = 0;
    step(1, 0, 0, 0, 1, 1, 32'h3333_0000, 4'b0111, 0);
    step(0, 0, 0, 1, 0, 0, 32'h77, 4'h0, 0);
    errFlagClr = 1; idle(1); idle(0); errFlagClr = 0; idle(0);

    // asynchronous reset while an error is being reported
    scen = "R9";
    step(1, 0, 0, 0, 1, 1, 32'h4444_0000, 4'b0111, 0);
    step(0, 0, 0, 0, 0, 0, 32'h9, 4'h0, 0);
    step(0, 0, 0, 1, 0, 0, 32'hA, 4'h0, 1);
    resetNow();
    idle(0); idle(0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule